// File: doc/BRIEF.md
# Prioritized Interrupt Vector Register

This block collects eight interrupt conditions raised by a serial multiplex-bus link controller. It presents the most urgent pending one as a byte-wide vector index. Firmware reads the byte and adds it to the base of a jump table, so it can branch straight into the right service routine. The index sits in bits 5..2 of the byte, so neighbouring entries are four bytes apart. A request line to the CPU is high while any condition is pending.

Each source has a one-cycle set pulse. The block decides when a source is cleared:

- Status-only sources clear on a read of the vector register.
- The three sources tied to the data register need a two-step sequence. First a vector read must show the source, which arms it. Then the matching data-register access clears it.
- The transmit-empty source can also be cleared at any time by a transmit-end-of-data control input.

Top module: `irq_vector_reg`

## Requirements
- R1: `vec_q` carries the 4-bit source code in bits 5..2. Bits 7, 6, 1 and 0 are always 0, so `vec_q` equals code×4.
- R2: Set input `src_set[i]` raises source code i+1. The codes are:
  - 1: end of frame
  - 2: response byte received
  - 3: receive data full
  - 4: transmit data empty
  - 5: arbitration lost
  - 6: CRC error
  - 7: bad symbol
  - 8: wakeup
- R3: With several sources pending, the vector shows the highest pending code.
- R4: A vector read (`vec_rd`) clears the displayed source when that source is code 1, 5, 6, 7 or 8.
- R5: A vector read leaves codes 2, 3 and 4 pending.
- R6: Codes 2 and 3 clear only on a data read (`dat_rd`) that follows a vector read which showed them. A data read without that arming has no effect.
- R7: Code 4 clears on a data write (`dat_wr`) that follows a vector read which showed it. A data write without that arming has no effect.
- R8: A cycle with `tx_eod` high clears code 4 whether or not it is armed.
- R9: A vector read that shows a different source disarms any earlier armed source. A later data access then leaves that earlier source pending.
- R10: A set pulse and a clear for the same source in the same cycle leave the source pending.
- R11: `vec_q` is registered. A set pulse or a clear takes effect on pending state at the edge that samples it, and `vec_q` changes at the following edge.
- R12: `irq` is high exactly when `vec_q` is non-zero.
- R13: Reset makes `vec_q` 0x00 and `irq` low, with nothing pending or armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 8 | One-cycle set pulses; bit i raises code i+1 |
| vec_rd | input | 1 | CPU read strobe of the vector register |
| dat_rd | input | 1 | CPU read strobe of the data register |
| dat_wr | input | 1 | CPU write strobe of the data register |
| tx_eod | input | 1 | Transmit end-of-data control; clears code 4 |
| vec_q | output | 8 | Vector byte, code in bits 5..2 |
| irq | output | 1 | Interrupt request, high while a source is pending |

## Verification
A source's set pulse and the clear that a CPU access or `tx_eod` produces can land in the same cycle. The bench provokes this in two cases:

- A wakeup is re-raised in the very cycle of the vector read that would clear it.
- A transmit-empty event is raised together with `tx_eod`.

In both cases the source must still show in `vec_q` two cycles later. The checker also requires that every set pulse leaves its bit pending at the next edge, whatever clear arrived with it.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NSRC    = 8;
  localparam int CODE_W  = $clog2(NSRC + 1);
  localparam int VEC_W   = 8;
  localparam int VEC_LSB = 2;

  // Source codes, lowest to highest priority
  typedef enum logic [CODE_W-1:0] {
    SRC_NONE   = 4'd0,
    SRC_EOF    = 4'd1,
    SRC_RSPBYT = 4'd2,
    SRC_RXFULL = 4'd3,
    SRC_TXEMPT = 4'd4,
    SRC_ARBLST = 4'd5,
    SRC_CRCERR = 4'd6,
    SRC_BADSYM = 4'd7,
    SRC_WAKE   = 4'd8
  } src_code_e;

  // Bit masks over pending bits (bit i holds code i+1)
  localparam logic [NSRC-1:0] RD_CLR_MASK = 8'b0000_0110; // codes 2,3
  localparam logic [NSRC-1:0] WR_CLR_MASK = 8'b0000_1000; // code 4
endpackage

// File: rtl/irqv_prio.sv
module irqv_prio
  import irqv_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int CW = CODE_W
) (
  input  logic [N-1:0]  pend,
  output logic [CW-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) code = CW'(i + 1);
    end
  end
endmodule

// File: rtl/irqv_arm.sv
module irqv_arm
  import irqv_pkg::*;
#(
  parameter int               N       = NSRC,
  parameter int               CW      = CODE_W,
  parameter logic [N-1:0]     RD_MASK = RD_CLR_MASK,
  parameter logic [N-1:0]     WR_MASK = WR_CLR_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vec_rd,
  input  logic [CW-1:0] disp_code,
  input  logic          dat_rd,
  input  logic          dat_wr,
  output logic [N-1:0]  disp_sel,
  output logic [N-1:0]  data_clr
);
  localparam logic [N-1:0] DATA_MASK = RD_MASK | WR_MASK;

  logic [N-1:0] arm_q;
  logic [N-1:0] arm_d;
  logic         arm_en;

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign disp_sel[g] = (disp_code == CW'(g + 1));
  end

  assign data_clr = arm_q & ((RD_MASK & {N{dat_rd}}) | (WR_MASK & {N{dat_wr}}));

  always_comb begin
    arm_d = arm_q & ~data_clr;
    if (vec_rd) arm_d = disp_sel & DATA_MASK;
  end

  assign arm_en = vec_rd | dat_rd | dat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= '0;
    else if (arm_en) arm_q <= arm_d;
  end
endmodule

// File: rtl/irqv_pend.sv
module irqv_pend #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend_q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic d;
    logic en;
    assign en = set[g] | clr[g];
    assign d  = set[g] | (pend_q[g] & ~clr[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pend_q[g] <= 1'b0;
      else if (en) pend_q[g] <= d;
    end
  end
endmodule

// File: rtl/irq_vector_reg.sv
module irq_vector_reg
  import irqv_pkg::*;
#(
  parameter int N     = NSRC,
  parameter int VW    = VEC_W,
  parameter int VLSB  = VEC_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_set,
  input  logic          vec_rd,
  input  logic          dat_rd,
  input  logic          dat_wr,
  input  logic          tx_eod,
  output logic [VW-1:0] vec_q,
  output logic          irq
);
  localparam int CW = $clog2(N + 1);
  localparam logic [N-1:0] DATA_MASK = RD_CLR_MASK | WR_CLR_MASK;

  logic [N-1:0]  pend_q;
  logic [N-1:0]  disp_sel;
  logic [N-1:0]  data_clr;
  logic [N-1:0]  clr;
  logic [CW-1:0] disp_code;
  logic [CW-1:0] top_code;
  logic [VW-1:0] vec_d;
  logic          vec_en;
  logic          irq_q;
  logic          irq_d;

  assign disp_code = vec_q[VLSB +: CW];

  irqv_arm #(.N(N), .CW(CW), .RD_MASK(RD_CLR_MASK), .WR_MASK(WR_CLR_MASK)) u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_rd    (vec_rd),
    .disp_code (disp_code),
    .dat_rd    (dat_rd),
    .dat_wr    (dat_wr),
    .disp_sel  (disp_sel),
    .data_clr  (data_clr)
  );

  always_comb begin
    clr = data_clr | (WR_CLR_MASK & {N{tx_eod}});
    if (vec_rd) clr = clr | (disp_sel & ~DATA_MASK);
  end

  irqv_pend #(.N(N)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (src_set),
    .clr    (clr),
    .pend_q (pend_q)
  );

  irqv_prio #(.N(N), .CW(CW)) u_prio (
    .pend (pend_q),
    .code (top_code)
  );

  always_comb begin
    vec_d = '0;
    vec_d[VLSB +: CW] = top_code;
    irq_d = |pend_q;
  end

  assign vec_en = (vec_d != vec_q) | (irq_d != irq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      irq_q <= 1'b0;
    end else if (vec_en) begin
      vec_q <= vec_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  src_set,
  input logic          dat_rd,
  input logic          dat_wr,
  input logic          tx_eod,
  input logic [N-1:0]  pend,
  input logic [VW-1:0] vec_q,
  input logic          irq
);
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_q[7:6] == 2'b00) && (vec_q[1:0] == 2'b00)); // R1

  AST_IRQ_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (vec_q != '0)); // R12

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((pend & $past(src_set)) == $past(src_set))); // R10

  AST_RXFULL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend[2]) |-> $past(dat_rd)); // R6

  AST_RSPBYT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend[1]) |-> $past(dat_rd)); // R6

  AST_TXEMPT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend[3]) |-> $past(dat_wr || tx_eod)); // R7

  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> (vec_q == '0)); // R11
endmodule

bind irq_vector_reg irqv_checker #(.N(N), .VW(VW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .src_set (src_set),
  .dat_rd  (dat_rd),
  .dat_wr  (dat_wr),
  .tx_eod  (tx_eod),
  .pend    (pend_q),
  .vec_q   (vec_q),
  .irq     (irq)
);

// File: tb/irq_vector_reg_bench.sv
module irq_vector_reg_bench;
  logic       clk;
  logic       rst_n;
  logic [7:0] src_set;
  logic       vec_rd, dat_rd, dat_wr, tx_eod;
  logic [7:0] vec_q;
  logic       irq;

  int n_chk;
  int n_fail;

  irq_vector_reg u_irq_vector_reg (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .vec_rd(vec_rd),
    .dat_rd(dat_rd), .dat_wr(dat_wr), .tx_eod(tx_eod),
    .vec_q(vec_q), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  typedef struct packed {
    logic [7:0] set;
    logic       vr;
    logic       dr;
    logic       dw;
    logic       eod;
    logic [7:0] exp;
  } step_t;

  // Each step: strobes for one cycle, one settle cycle, then vec_q compared
  localparam step_t TBL [0:20] = '{
    '{8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04}, // R2 code1
    '{8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20}, // R3 wake over eof
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h04}, // R4 read clears wake
    '{8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0C}, // R2 code3
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0C}, // R5 read keeps code3
    '{8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h04}, // R6 data read clears
    '{8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10}, // R2 code4
    '{8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10}, // R7 unarmed write
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h10}, // R5 arm code4
    '{8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h04}, // R7 armed write
    '{8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 8'h08}, // R2 code2
    '{8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h08}, // R6 unarmed read
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h08}, // R5 arm code2
    '{8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h04}, // R6 armed read
    '{8'h70, 1'b0, 1'b0, 1'b0, 1'b0, 8'h1C}, // R3 codes 5,6,7
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h18}, // R4
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h14}, // R4
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h04}, // R4
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R4 empty
    '{8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10}, // R2 code4 again
    '{8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00}  // R8 eod clears
  };

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] s, input logic vr, input logic dr,
                      input logic dw, input logic e);
    src_set = s; vec_rd = vr; dat_rd = dr; dat_wr = dw; tx_eod = e;
    @(negedge clk);
    src_set = '0; vec_rd = 1'b0; dat_rd = 1'b0; dat_wr = 1'b0; tx_eod = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    src_set = '0; vec_rd = 0; dat_rd = 0; dat_wr = 0; tx_eod = 0;
    rst_n = 1'b0;
    @(negedge clk);
    // R13 reset state
    check8("R13 vec after reset", vec_q, 8'h00);
    check8("R13 irq after reset", {7'd0, irq}, 8'h00);
    do_reset();

    foreach (TBL[k]) begin
      step(TBL[k].set, TBL[k].vr, TBL[k].dr, TBL[k].dw, TBL[k].eod);
      check8($sformatf("R2/R3 table step %0d", k), vec_q, TBL[k].exp);
      // R12 request follows vector, R1 padding
      check8($sformatf("R12 irq step %0d", k), {7'd0, irq}, {7'd0, TBL[k].exp != 8'h00});
      check8($sformatf("R1 pad step %0d", k), vec_q & 8'hC3, 8'h00);
    end

    // R11 latency: vector unchanged one cycle after the set edge
    do_reset();
    src_set = 8'h40;
    @(negedge clk);
    src_set = '0;
    check8("R11 vec one cycle after set", vec_q, 8'h00);
    @(negedge clk);
    check8("R11 vec two cycles after set", vec_q, 8'h1C);

    // R10 set collides with the vector-read clear of the same source
    do_reset();
    step(8'h80, 0, 0, 0, 0);
    check8("R10 wake shown", vec_q, 8'h20);
    step(8'h80, 1, 0, 0, 0);
    check8("R10 set beats read clear", vec_q, 8'h20);
    step(8'h00, 1, 0, 0, 0);
    check8("R4 wake cleared after", vec_q, 8'h00);

    // R10 set collides with tx_eod clear
    step(8'h08, 0, 0, 0, 1);
    check8("R10 set beats eod clear", vec_q, 8'h10);
    step(8'h00, 0, 0, 0, 1);
    check8("R8 eod clears unarmed", vec_q, 8'h00);

    // R9 arming dropped by a read of a different source
    do_reset();
    step(8'h04, 0, 0, 0, 0);
    step(8'h00, 1, 0, 0, 0);          // arms code3
    step(8'h80, 0, 0, 0, 0);
    check8("R9 wake displayed", vec_q, 8'h20);
    step(8'h00, 1, 0, 0, 0);          // shows wake, disarms code3
    check8("R9 back to code3", vec_q, 8'h0C);
    step(8'h00, 0, 1, 0, 0);
    check8("R9 stale arm has no effect", vec_q, 8'h0C);
    step(8'h00, 1, 0, 0, 0);
    step(8'h00, 0, 1, 0, 0);
    check8("R6 rearmed read clears", vec_q, 8'h00);

    // R7 data read does not clear transmit-empty even when armed
    step(8'h08, 0, 0, 0, 0);
    step(8'h00, 1, 0, 0, 0);
    step(8'h00, 0, 1, 0, 0);
    check8("R7 read does not clear code4", vec_q, 8'h10);

    // R13 reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check8("R13 vec under reset", vec_q, 8'h00);
    check8("R13 irq under reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check8("R13 nothing pending after reset", vec_q, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule